// File: doc/BRIEF.md
# Deblocking Edge Decision Mask Generator

This block decides how one pixel line that crosses a block boundary should be smoothed. It takes eight samples on each side of the boundary (near side p0..p7, far side q0..q7, with p0 and q0 touching the boundary) and three 8-bit thresholds: an edge-strength limit, an interior-step limit and a variance limit. From them it forms four flags: filter enable, high variance, inner flatness and outer flatness. It then makes a single prioritised choice among four filter types, or none.

The samples, thresholds and an edge-size mode are captured together on a valid strobe. The flags and the choice appear one clock later and hold until the next strobe. The smallest edge size skips both flatness tests. The middle size skips only the outer one. A downstream filter datapath uses the one-hot choice to pick which taps to rewrite.

Top module: `lf_edge_mask`

## Requirements
- R1: While reset is high, and after it until the first strobe, `out_valid`, `filt_en`, `hev`, `flat_in`, `flat_out` and `sel` are all 0.
- R2: `out_valid` is `in_valid` delayed by one clock. The flags and `sel` reflect the inputs present in the cycle `in_valid` was 1. While `in_valid` is 0, the inputs are ignored and the outputs hold.
- R3: `filt_en` needs each adjacent-pair absolute difference among p3,p2,p1,p0 and among q0,q1,q2,q3 to be no more than `thr_i`.
- R4: `filt_en` also needs min(255, min(255, 2*|p0-q0|) + (|p1-q1| >> 1)) to be no more than `thr_e`. All comparisons are unsigned.
- R5: `hev` is 1 when |p1-p0| > `thr_h` or |q1-q0| > `thr_h`.
- R6: `flat_in` is 1 when |p1-p0|, |p2-p0|, |p3-p0|, |q1-q0|, |q2-q0| and |q3-q0| are each at most 1, and `mode` is not 0.
- R7: `flat_out` is 1 when |p4..p7 - p0| and |q4..q7 - q0| are each at most 1, and `mode` is 2 or 3. With `mode` 1 it is 0.
- R8: The fields of `sel` are as follows. `sel[3]` (wide) = enable & outer & inner. `sel[2]` (medium) = enable & !outer & inner. `sel[1]` (narrow, p1/q1 untouched) = enable & !inner & hev. `sel[0]` (narrow, p1/q1 updated) = enable & !inner & !hev.
- R9: When `filt_en` is 0, `sel` is 0. When `filt_en` is 1, exactly one bit of `sel` is 1.
- R10: Mode encoding: 0 is the smallest edge, where only `sel[1]` or `sel[0]` can be chosen. 1 is the middle edge. 2 and 3 are both the widest edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for samples, thresholds and mode |
| mode | input | 2 | Edge size (0 smallest, 1 middle, 2/3 widest) |
| p_pix | input | 64 | Near-side samples, byte k = pk |
| q_pix | input | 64 | Far-side samples, byte k = qk |
| thr_e | input | 8 | Edge-strength limit |
| thr_i | input | 8 | Interior-step limit |
| thr_h | input | 8 | Variance limit |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| filt_en | output | 1 | Filter enable flag |
| hev | output | 1 | High variance flag |
| flat_in | output | 1 | Inner flatness flag |
| flat_out | output | 1 | Outer flatness flag |
| sel | output | 4 | One-hot filter choice, all zero for none |

## Verification
Only the output register holds state. A bad capture shows at the ports one clock after the strobe, as a wrong flag or a wrong `sel`. A missing hold shows as outputs changing during idle cycles. Vectors sit just on each side of every threshold and of the flatness limit of 1. This exposes off-by-one comparisons. A lost saturation in the edge sum only shows when the doubled boundary step passes 255, so one vector pair covers that case. Each mode is applied to the same samples, to show that a test skipped by the mode cannot leak into the choice.

// File: rtl/lf_edge_mask_pkg.sv
package lf_edge_mask_pkg;

    typedef enum logic [1:0] {
        EM_SMALL  = 2'd0,
        EM_MIDDLE = 2'd1,
        EM_WIDE   = 2'd2,
        EM_WIDE_B = 2'd3
    } edge_mode_e;

    localparam int unsigned SEL_W          = 4;
    localparam int unsigned SEL_NARROW_ALL = 0;
    localparam int unsigned SEL_NARROW_HEV = 1;
    localparam int unsigned SEL_MEDIUM     = 2;
    localparam int unsigned SEL_WIDE       = 3;

    typedef struct packed {
        logic enable;
        logic hev;
        logic flat_in;
        logic flat_out;
    } edge_flags_t;

    function automatic logic mode_uses_inner(input edge_mode_e m);
        return m != EM_SMALL;
    endfunction

    function automatic logic mode_uses_outer(input edge_mode_e m);
        return m[1];
    endfunction

    function automatic logic [SEL_W-1:0] pick_filter(input edge_flags_t f);
        logic [SEL_W-1:0] s;
        s = '0;
        if (f.enable) begin
            if (f.flat_in && f.flat_out)      s[SEL_WIDE]       = 1'b1;
            else if (f.flat_in)               s[SEL_MEDIUM]     = 1'b1;
            else if (f.hev)                   s[SEL_NARROW_HEV] = 1'b1;
            else                              s[SEL_NARROW_ALL] = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/lf_edge_gate.sv
module lf_edge_gate #(
    parameter int PIX_W = 8,
    parameter int NTAP  = 8
) (
    input  logic [NTAP*PIX_W-1:0] p_pix,
    input  logic [NTAP*PIX_W-1:0] q_pix,
    input  logic [PIX_W-1:0]      thr_e,
    input  logic [PIX_W-1:0]      thr_i,
    output logic                  enable
);
    localparam int INNER = 4;
    localparam int STEPS = INNER - 1;
    localparam int SUM_W = PIX_W + 2;
    localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((1 << PIX_W) - 1);

    function automatic logic [PIX_W-1:0] adiff(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic [2*STEPS-1:0] step_ok;

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        assign step_ok[k] =
            adiff(p_pix[k*PIX_W +: PIX_W], p_pix[(k+1)*PIX_W +: PIX_W]) <= thr_i;
        assign step_ok[STEPS+k] =
            adiff(q_pix[k*PIX_W +: PIX_W], q_pix[(k+1)*PIX_W +: PIX_W]) <= thr_i;
    end

    logic [PIX_W-1:0] d_zero;
    logic [PIX_W-1:0] d_one;
    logic [PIX_W-1:0] d_half;
    logic [SUM_W-1:0] raw_sum;
    logic [PIX_W-1:0] sat_sum;

    always_comb begin
        d_zero  = adiff(p_pix[0 +: PIX_W], q_pix[0 +: PIX_W]);
        d_one   = adiff(p_pix[PIX_W +: PIX_W], q_pix[PIX_W +: PIX_W]);
        d_half  = d_one >> 1;
        raw_sum = {1'b0, d_zero, 1'b0} + {2'b00, d_half};
        sat_sum = (raw_sum > SAT_MAX) ? SAT_MAX[PIX_W-1:0] : raw_sum[PIX_W-1:0];
    end

    assign enable = (&step_ok) && (sat_sum <= thr_e);

endmodule

// File: rtl/lf_flat_span.sv
module lf_flat_span #(
    parameter int PIX_W = 8,
    parameter int NTAP  = 8,
    parameter int FIRST = 1,
    parameter int LAST  = 3
) (
    input  logic [NTAP*PIX_W-1:0] pix,
    output logic                  flat
);
    localparam int SPAN = LAST - FIRST + 1;

    function automatic logic [PIX_W-1:0] adiff(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic [SPAN-1:0] near;

    for (genvar k = 0; k < SPAN; k++) begin : g_tap
        assign near[k] =
            adiff(pix[(FIRST+k)*PIX_W +: PIX_W], pix[0 +: PIX_W]) <= PIX_W'(1);
    end

    assign flat = &near;

endmodule

// File: rtl/lf_hev_detect.sv
module lf_hev_detect #(
    parameter int PIX_W = 8,
    parameter int NTAP  = 8
) (
    input  logic [NTAP*PIX_W-1:0] p_pix,
    input  logic [NTAP*PIX_W-1:0] q_pix,
    input  logic [PIX_W-1:0]      thr_h,
    output logic                  hev
);
    function automatic logic [PIX_W-1:0] adiff(input logic [PIX_W-1:0] a,
                                               input logic [PIX_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic p_big;
    logic q_big;

    assign p_big = adiff(p_pix[PIX_W +: PIX_W], p_pix[0 +: PIX_W]) > thr_h;
    assign q_big = adiff(q_pix[PIX_W +: PIX_W], q_pix[0 +: PIX_W]) > thr_h;
    assign hev   = p_big || q_big;

endmodule

// File: rtl/lf_filter_select.sv
module lf_filter_select
    import lf_edge_mask_pkg::*;
(
    input  edge_mode_e        mode,
    input  logic              enable,
    input  logic              hev,
    input  logic              inner_p,
    input  logic              inner_q,
    input  logic              outer_p,
    input  logic              outer_q,
    output edge_flags_t       flags,
    output logic [SEL_W-1:0]  sel
);
    always_comb begin
        flags.enable   = enable;
        flags.hev      = hev;
        flags.flat_in  = inner_p && inner_q && mode_uses_inner(mode);
        flags.flat_out = outer_p && outer_q && mode_uses_outer(mode);
        sel            = pick_filter(flags);
    end

endmodule

// File: rtl/lf_edge_mask.sv
module lf_edge_mask
    import lf_edge_mask_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int NTAP  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            mode,
    input  logic [NTAP*PIX_W-1:0] p_pix,
    input  logic [NTAP*PIX_W-1:0] q_pix,
    input  logic [PIX_W-1:0]      thr_e,
    input  logic [PIX_W-1:0]      thr_i,
    input  logic [PIX_W-1:0]      thr_h,
    output logic                  out_valid,
    output logic                  filt_en,
    output logic                  hev,
    output logic                  flat_in,
    output logic                  flat_out,
    output logic [3:0]            sel
);
    localparam int INNER_LAST = 3;
    localparam int OUTER_FIRST = INNER_LAST + 1;

    logic        en_c;
    logic        hev_c;
    logic        in_p_c;
    logic        in_q_c;
    logic        out_p_c;
    logic        out_q_c;
    edge_flags_t flags_c;
    logic [SEL_W-1:0] sel_c;

    lf_edge_gate #(.PIX_W(PIX_W), .NTAP(NTAP)) u_gate (
        .p_pix (p_pix),
        .q_pix (q_pix),
        .thr_e (thr_e),
        .thr_i (thr_i),
        .enable(en_c)
    );

    lf_hev_detect #(.PIX_W(PIX_W), .NTAP(NTAP)) u_hev (
        .p_pix(p_pix),
        .q_pix(q_pix),
        .thr_h(thr_h),
        .hev  (hev_c)
    );

    lf_flat_span #(.PIX_W(PIX_W), .NTAP(NTAP), .FIRST(1), .LAST(INNER_LAST))
        u_in_p (.pix(p_pix), .flat(in_p_c));
    lf_flat_span #(.PIX_W(PIX_W), .NTAP(NTAP), .FIRST(1), .LAST(INNER_LAST))
        u_in_q (.pix(q_pix), .flat(in_q_c));
    lf_flat_span #(.PIX_W(PIX_W), .NTAP(NTAP), .FIRST(OUTER_FIRST), .LAST(NTAP-1))
        u_out_p (.pix(p_pix), .flat(out_p_c));
    lf_flat_span #(.PIX_W(PIX_W), .NTAP(NTAP), .FIRST(OUTER_FIRST), .LAST(NTAP-1))
        u_out_q (.pix(q_pix), .flat(out_q_c));

    lf_filter_select u_sel (
        .mode   (edge_mode_e'(mode)),
        .enable (en_c),
        .hev    (hev_c),
        .inner_p(in_p_c),
        .inner_q(in_q_c),
        .outer_p(out_p_c),
        .outer_q(out_q_c),
        .flags  (flags_c),
        .sel    (sel_c)
    );

    edge_flags_t      flags_q;
    logic [SEL_W-1:0] sel_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            sel_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                flags_q <= flags_c;
                sel_q   <= sel_c;
            end
        end
    end

    assign out_valid = vld_q;
    assign filt_en   = flags_q.enable;
    assign hev       = flags_q.hev;
    assign flat_in   = flags_q.flat_in;
    assign flat_out  = flags_q.flat_out;
    assign sel       = sel_q;

endmodule

// File: rtl/lf_edge_mask_chk.sv
module lf_edge_mask_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [1:0] mode,
    input logic       out_valid,
    input logic       filt_en,
    input logic       hev,
    input logic       flat_in,
    input logic       flat_out,
    input logic [3:0] sel
);
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable({filt_en, hev, flat_in, flat_out, sel}));
    a_r9_one_choice: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    a_r9_off_gate: assert property (@(posedge clk) disable iff (rst)
        !filt_en |-> (sel == 4'b0000));
    a_r9_on_picks: assert property (@(posedge clk) disable iff (rst)
        filt_en |-> (sel != 4'b0000));
    a_r8_wide: assert property (@(posedge clk) disable iff (rst)
        sel[3] |-> (flat_in && flat_out));
    a_r8_medium: assert property (@(posedge clk) disable iff (rst)
        sel[2] |-> (flat_in && !flat_out));
    a_r8_narrow_hev: assert property (@(posedge clk) disable iff (rst)
        sel[1] |-> (hev && !flat_in));
    a_r8_narrow_all: assert property (@(posedge clk) disable iff (rst)
        sel[0] |-> (!hev && !flat_in));
    a_r10_small_mode: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd0) |=> (sel[3:2] == 2'b00 && !flat_in && !flat_out));
    a_r7_middle_mode: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd1) |=> !flat_out);
endmodule

bind lf_edge_mask lf_edge_mask_chk u_chk (.*);

// File: tb/lf_edge_mask_bench.sv
module lf_edge_mask_bench;

    typedef struct packed {
        logic [1:0]  mode;
        logic [63:0] p;
        logic [63:0] q;
        logic [7:0]  e;
        logic [7:0]  i;
        logic [7:0]  h;
        logic [7:0]  exp;   // {filt_en, hev, flat_in, flat_out, sel[3:0]}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam logic [63:0] F80 = 64'h8080_8080_8080_8080;
    localparam logic [63:0] F50 = 64'h5050_5050_5050_5050;

    localparam vec_t VECS [NV] = '{
        '{2'd2, F80, F80, 8'h00, 8'h00, 8'h00, 8'hB8, 4'd8},                     // R8 wide
        '{2'd1, F80, F80, 8'h00, 8'h00, 8'h00, 8'hA4, 4'd7},                     // R7 middle mode
        '{2'd0, F80, F80, 8'h00, 8'h00, 8'h00, 8'h81, 4'd10},                    // R10 small mode
        '{2'd2, 64'h4040_4040_4040_4040, 64'h4444_4444_4444_4444,
               8'h08, 8'h00, 8'h00, 8'h30, 4'd4},                                // R4 sum 10 > 8
        '{2'd2, 64'h4040_4040_4040_4040, 64'h4444_4444_4444_4444,
               8'h0A, 8'h00, 8'h00, 8'hB8, 4'd4},                                // R4 sum 10 <= 10
        '{2'd2, 64'h5050_5050_5053_5050, F50, 8'hFF, 8'h03, 8'h02, 8'h91, 4'd3}, // R3 step 3 <= 3
        '{2'd2, 64'h5050_5050_5053_5050, F50, 8'hFF, 8'h02, 8'h02, 8'h10, 4'd9}, // R9 step 3 > 2
        '{2'd2, 64'h5050_5050_5050_5250, F50, 8'hFF, 8'h04, 8'h01, 8'hD2, 4'd5}, // R5 2 > 1
        '{2'd2, 64'h5050_5050_5050_5250, F50, 8'hFF, 8'h04, 8'h02, 8'h91, 4'd5}, // R5 2 <= 2
        '{2'd2, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 8'h00, 8'hFF, 8'hB8, 4'd4}, // R4 saturate ok
        '{2'd2, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFE, 8'h00, 8'hFF, 8'h30, 4'd4}, // R4 255 > 254
        '{2'd2, F80, 64'h8280_8080_8080_8080, 8'h00, 8'h00, 8'h00, 8'hA4, 4'd7}, // R7 q7 off by 2
        '{2'd2, F80, 64'h8180_8080_8080_8080, 8'h00, 8'h00, 8'h00, 8'hB8, 4'd7}, // R7 q7 off by 1
        '{2'd2, F80, 64'h8080_8080_8180_8080, 8'h00, 8'h01, 8'h00, 8'hB8, 4'd6}, // R6 q3 off by 1
        '{2'd2, F80, 64'h8080_8080_7E80_8080, 8'h00, 8'h02, 8'h00, 8'h91, 4'd6}, // R6 q3 off by 2
        '{2'd3, F80, F80, 8'h00, 8'h00, 8'h00, 8'hB8, 4'd10},                    // R10 mode 3 wide
        '{2'd0, 64'h5050_5050_5050_5250, F50, 8'hFF, 8'h04, 8'h01, 8'hC2, 4'd10} // R10 small + hev
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  mode;
    logic [63:0] p_pix;
    logic [63:0] q_pix;
    logic [7:0]  thr_e, thr_i, thr_h;
    logic        out_valid, filt_en, hev, flat_in, flat_out;
    logic [3:0]  sel;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lf_edge_mask u_lf_edge_mask (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .p_pix(p_pix), .q_pix(q_pix), .thr_e(thr_e), .thr_i(thr_i), .thr_h(thr_h),
        .out_valid(out_valid), .filt_en(filt_en), .hev(hev),
        .flat_in(flat_in), .flat_out(flat_out), .sel(sel)
    );

    function automatic logic [7:0] result();
        return {filt_en, hev, flat_in, flat_out, sel};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic vld);
        mode     = v.mode;
        p_pix    = v.p;
        q_pix    = v.q;
        thr_e    = v.e;
        thr_i    = v.i;
        thr_h    = v.h;
        in_valid = vld;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        apply(VECS[0], 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 outputs in reset", {23'd0, out_valid, result()}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", {23'd0, out_valid, result()}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k], 1'b1);
            @(negedge clk);
            check($sformatf("R2 out_valid vector %0d", k), {31'd0, out_valid}, 32'd1);
            check($sformatf("R%0d vector %0d", VECS[k].req, k),
                  {24'd0, result()}, {24'd0, VECS[k].exp});
            in_valid = 1'b0;
            @(negedge clk);
            check($sformatf("R2 out_valid drop %0d", k), {31'd0, out_valid}, 32'd0);
        end

        // R2: inputs ignored while the strobe is low
        apply(VECS[0], 1'b1);
        @(negedge clk);
        check("R2 hold setup", {24'd0, result()}, 32'hB8);
        apply(VECS[3], 1'b0);
        repeat (2) @(negedge clk);
        check("R2 hold value", {24'd0, result()}, 32'hB8);
        check("R2 hold valid", {31'd0, out_valid}, 32'd0);
        // R8: strobe now takes the held inputs
        in_valid = 1'b1;
        @(negedge clk);
        check("R8 after hold", {24'd0, result()}, 32'h30);
        in_valid = 1'b0;

        // R1: reset clears a loaded result
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reclear", {23'd0, out_valid, result()}, 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule